// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one down-counting timer channel of a programmable interval timer. It decrements a 16-bit count on each pulse of a count-enable input that stands in for the channel's counting clock. What the output does depends on one of six counting behaviours. Each behaviour reads a gate input in its own way: either as a level that pauses counting, or as a rising edge that starts or restarts a count. The count can run as a plain binary number or as four packed decimal digits.

A register interface outside this block writes two things. The first is a mode word, which holds a 3-bit behaviour code and a decimal-select bit. The second is a count value. Writing the count raises a one-cycle "count loaded" strobe. Everything is synchronous to one system clock. The counting clock arrives as a single-cycle enable pulse `tick_i`. The gate input is assumed to be already synchronous to the system clock.

In all descriptions below, a "tick" is a system clock cycle in which `tick_i` is high. N is the value written to the count.

Top module: `tmr_channel`

## Requirements
- R1: After reset `out_o` is high and `loaded_o` is low.
- R2: The behaviour code decodes as follows: 000 terminal-count, 001 gate one-shot, 010 and 110 rate divider, 011 and 111 square wave, 100 software strobe, 101 gate strobe. Bit 2 has no effect on the two divider behaviours.
- R3: A count write raises `loaded_o` for exactly the one cycle after the write.
- R4: Terminal-count (000): a mode write drives `out_o` low. After a count write, `out_o` goes high on the Nth counted tick and stays high until the next mode or count write.
- R5: In behaviours 000, 01x, 11x and 100, a tick taken while `gate_i` is low is not counted and leaves `out_o` unchanged.
- R6: Gate one-shot (001): a rising edge of `gate_i` arms a trigger. The first tick after the edge loads N and drives `out_o` low. `out_o` returns high on the Nth tick after that. A new rising edge before then restarts the count.
- R7: Rate divider: `out_o` is low for one tick in every N ticks. It is low while the count stands at 1, and the count reloads N on the next tick.
- R8: Square wave: the period is N ticks. `out_o` is high for (N+1)/2 ticks and low for N/2 ticks, rounding down in both cases.
- R9: Software strobe (100): `out_o` goes low on the Nth counted tick after the count write and returns high on the next tick. It fires only once for each count write.
- R10: Gate strobe (101): the first tick after a rising gate edge loads N. `out_o` goes low for one tick on the Nth tick after that load.
- R11: With decimal select set, each 4-bit digit steps from 0 to 9 with a borrow. A count of 0x0010 therefore expires after 10 ticks rather than 16.
- R12: A written count of 0 expires after 65536 ticks in binary and after 10000 ticks in decimal.
- R13: Between a mode write and the next count write, ticks and gate edges do not change `out_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Counting clock as a one-cycle enable |
| gate_i | input | 1 | Gate, read as a level or as a rising edge depending on the behaviour |
| mode_we_i | input | 1 | Mode word write strobe |
| mode_code_i | input | 3 | Behaviour code |
| bcd_sel_i | input | 1 | 1 selects decimal counting |
| count_we_i | input | 1 | Count write strobe |
| count_i | input | CNT_W | Count value N |
| out_o | output | 1 | Channel output |
| loaded_o | output | 1 | One-cycle strobe after a count write |

## Verification
The bench builds the channel with the default `CNT_W` of 16, which gives four decimal digits. With that width the full-range zero count is cheap enough to run: 65536 ticks in binary and 10000 in decimal, one tick every cycle. This is what brings the wrap of the binary and decimal decrementers within reach. The other tests use short counts of 3 to 15. Short counts give several complete output periods, gate-low pauses in the middle of a period, and retriggers in the middle of a count, all inside a few dozen ticks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [2:0] {
        MD_TERM    = 3'd0,
        MD_ONESHOT = 3'd1,
        MD_RATE    = 3'd2,
        MD_SQUARE  = 3'd3,
        MD_SWSTB   = 3'd4,
        MD_HWSTB   = 3'd5
    } tmr_mode_e;

    typedef struct packed {
        tmr_mode_e mode;
        logic      bcd;
    } tmr_cfg_t;

    // Bit 2 is a don't-care for the two divider behaviours.
    function automatic tmr_mode_e decode_mode(input logic [2:0] code);
        tmr_mode_e m;
        casez (code)
            3'b000:  m = MD_TERM;
            3'b001:  m = MD_ONESHOT;
            3'b?10:  m = MD_RATE;
            3'b?11:  m = MD_SQUARE;
            3'b100:  m = MD_SWSTB;
            default: m = MD_HWSTB;
        endcase
        return m;
    endfunction

    function automatic logic is_gate_triggered(input tmr_mode_e m);
        return (m == MD_ONESHOT) || (m == MD_HWSTB);
    endfunction

endpackage

// File: rtl/tmr_gate_edge.sv
module tmr_gate_edge (
    input  logic clk,
    input  logic rst,
    input  logic gate_i,
    output logic rise_o
);
    logic gate_q;

    always_ff @(posedge clk) begin
        if (rst) gate_q <= 1'b0;
        else     gate_q <= gate_i;
    end

    assign rise_o = gate_i & ~gate_q;

endmodule

// File: rtl/tmr_decr.sv
// Subtract one from the count, either as a binary number or as packed decimal digits.
module tmr_decr #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] val_i,
    input  logic             bcd_i,
    output logic [CNT_W-1:0] res_o
);
    localparam int DIGITS = CNT_W / 4;

    logic [CNT_W-1:0] dec_res;

    for (genvar d = 0; d < DIGITS; d++) begin : g_dig
        localparam logic [CNT_W-1:0] LOW_MASK = (CNT_W'(1) << (4 * d)) - CNT_W'(1);
        logic [3:0] dv;
        logic       borrow_in;

        assign dv        = val_i[4*d +: 4];
        // A digit takes a borrow when every digit below it is zero.
        assign borrow_in = ((val_i & LOW_MASK) == '0);
        assign dec_res[4*d +: 4] = !borrow_in   ? dv :
                                   (dv == 4'd0) ? 4'd9 : dv - 4'd1;

        always_comb begin
            if (bcd_i && (dv <= 4'd9)) begin
                AST_BCD_DIGIT_RANGE: assert (dec_res[4*d +: 4] <= 4'd9); // R11
            end
        end
    end

    assign res_o = bcd_i ? dec_res : (val_i - CNT_W'(1));

endmodule

// File: rtl/tmr_half.sv
// Give floor(N/2) for the square wave, in binary or in packed decimal; a count of 0 stands for full scale.
module tmr_half #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] val_i,
    input  logic             bcd_i,
    output logic [CNT_W-1:0] half_o
);
    localparam int DIGITS = CNT_W / 4;

    logic [CNT_W-1:0] dec_half;

    for (genvar d = 0; d < DIGITS; d++) begin : g_dig
        logic [3:0] dv;
        assign dv = val_i[4*d +: 4];
        if (d == DIGITS - 1) begin : g_top
            assign dec_half[4*d +: 4] = {1'b0, dv[3:1]};
        end else begin : g_low
            // An odd digit above passes ten down, which halves to five.
            assign dec_half[4*d +: 4] = {1'b0, dv[3:1]} + (val_i[4*d+4] ? 4'd5 : 4'd0);
        end
    end

    always_comb begin
        if (val_i == '0)
            half_o = bcd_i ? {4'd5, {(CNT_W-4){1'b0}}} : {1'b1, {(CNT_W-1){1'b0}}};
        else
            half_o = bcd_i ? dec_half : (val_i >> 1);
    end

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             gate_i,
    input  logic             gate_rise_i,
    input  logic             mode_we_i,
    input  tmr_cfg_t         cfg_i,
    input  logic             count_we_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] cnt_dec_i,
    input  logic [CNT_W-1:0] reload_half_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] reload_o,
    output logic             bcd_o,
    output logic             out_o,
    output logic             loaded_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    tmr_cfg_t         cfg_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload_q;
    logic             out_q;
    logic             armed_q;
    logic             run_q;
    logic             trig_q;
    logic             loaded_q;

    logic             at_one;
    logic             no_write;
    logic [CNT_W-1:0] wrap_val;
    logic             sq_level;
    logic             trig_set;

    assign at_one   = (cnt_q == ONE);
    assign no_write = !mode_we_i && !count_we_i;
    assign wrap_val = at_one ? reload_q : cnt_dec_i;
    assign sq_level = (wrap_val == '0) || (wrap_val > reload_half_i);
    assign trig_set = gate_rise_i && armed_q && is_gate_triggered(cfg_q.mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '{mode: MD_TERM, bcd: 1'b0};
            cnt_q    <= '0;
            reload_q <= '0;
            out_q    <= 1'b1;
            armed_q  <= 1'b0;
            run_q    <= 1'b0;
            trig_q   <= 1'b0;
            loaded_q <= 1'b0;
        end else begin
            loaded_q <= count_we_i && !mode_we_i;
            if (mode_we_i) begin
                cfg_q   <= cfg_i;
                armed_q <= 1'b0;
                run_q   <= 1'b0;
                trig_q  <= 1'b0;
                out_q   <= (cfg_i.mode != MD_TERM);
            end else if (count_we_i) begin
                reload_q <= count_i;
                cnt_q    <= count_i;
                armed_q  <= 1'b1;
                run_q    <= 1'b0;
                trig_q   <= 1'b0;
                case (cfg_q.mode)
                    MD_TERM:                      out_q <= 1'b0;
                    MD_RATE, MD_SQUARE, MD_SWSTB: out_q <= 1'b1;
                    default:                      out_q <= out_q;
                endcase
            end else begin
                trig_q <= (trig_q && !tick_i) || trig_set;
                if (tick_i) begin
                    case (cfg_q.mode)
                        MD_TERM: begin
                            if (armed_q && gate_i) begin
                                cnt_q <= cnt_dec_i;
                                if (at_one) out_q <= 1'b1;
                            end
                        end
                        MD_ONESHOT: begin
                            if (trig_q) begin
                                cnt_q <= reload_q;
                                out_q <= 1'b0;
                                run_q <= 1'b1;
                            end else if (run_q) begin
                                cnt_q <= cnt_dec_i;
                                if (at_one) begin
                                    out_q <= 1'b1;
                                    run_q <= 1'b0;
                                end
                            end
                        end
                        MD_RATE: begin
                            if (armed_q && gate_i) begin
                                cnt_q <= wrap_val;
                                out_q <= (wrap_val != ONE);
                            end
                        end
                        MD_SQUARE: begin
                            if (armed_q && gate_i) begin
                                cnt_q <= wrap_val;
                                out_q <= sq_level;
                            end
                        end
                        MD_SWSTB: begin
                            if (!out_q) begin
                                out_q <= 1'b1;
                            end else if (armed_q && gate_i) begin
                                cnt_q <= cnt_dec_i;
                                if (at_one) begin
                                    out_q   <= 1'b0;
                                    armed_q <= 1'b0;
                                end
                            end
                        end
                        default: begin
                            if (!out_q) out_q <= 1'b1;
                            if (trig_q) begin
                                cnt_q <= reload_q;
                                run_q <= 1'b1;
                            end else if (run_q) begin
                                cnt_q <= cnt_dec_i;
                                if (at_one) begin
                                    out_q <= 1'b0;
                                    run_q <= 1'b0;
                                end
                            end
                        end
                    endcase
                end
            end
        end
    end

    assign cnt_o    = cnt_q;
    assign reload_o = reload_q;
    assign bcd_o    = cfg_q.bcd;
    assign out_o    = out_q;
    assign loaded_o = loaded_q;

    AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
        (!armed_q && !count_we_i) |=> $stable(cnt_q)); // R13

    AST_TERM_HOLDS_HIGH: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == MD_TERM && out_q && no_write) |=> out_q); // R4

    AST_ONESHOT_TRIG_LOW: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == MD_ONESHOT && trig_q && tick_i && no_write) |=> !out_q); // R6

    AST_RATE_ONE_TICK_LOW: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == MD_RATE && armed_q && !out_q && tick_i && gate_i && no_write
         && reload_q != ONE) |=> out_q); // R7

    AST_SWSTB_ONE_TICK_LOW: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == MD_SWSTB && !out_q && tick_i && no_write) |=> out_q); // R9

    AST_HWSTB_ONE_TICK_LOW: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == MD_HWSTB && !out_q && tick_i && no_write) |=> out_q); // R10

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             gate_i,
    input  logic             mode_we_i,
    input  logic [2:0]       mode_code_i,
    input  logic             bcd_sel_i,
    input  logic             count_we_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             out_o,
    output logic             loaded_o
);
    tmr_cfg_t         cfg_in;
    logic             gate_rise;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_dec;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] reload_half;
    logic             bcd;

    assign cfg_in.mode = decode_mode(mode_code_i);
    assign cfg_in.bcd  = bcd_sel_i;

    tmr_gate_edge u_gate (
        .clk    (clk),
        .rst    (rst),
        .gate_i (gate_i),
        .rise_o (gate_rise)
    );

    tmr_decr #(.CNT_W(CNT_W)) u_decr (
        .val_i (cnt),
        .bcd_i (bcd),
        .res_o (cnt_dec)
    );

    tmr_half #(.CNT_W(CNT_W)) u_half (
        .val_i  (reload),
        .bcd_i  (bcd),
        .half_o (reload_half)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk           (clk),
        .rst           (rst),
        .tick_i        (tick_i),
        .gate_i        (gate_i),
        .gate_rise_i   (gate_rise),
        .mode_we_i     (mode_we_i),
        .cfg_i         (cfg_in),
        .count_we_i    (count_we_i),
        .count_i       (count_i),
        .cnt_dec_i     (cnt_dec),
        .reload_half_i (reload_half),
        .cnt_o         (cnt),
        .reload_o      (reload),
        .bcd_o         (bcd),
        .out_o         (out_o),
        .loaded_o      (loaded_o)
    );

    AST_LOADED_STROBE: assert property (@(posedge clk) disable iff (rst)
        (count_we_i && !mode_we_i) |=> loaded_o); // R3

endmodule

// File: tb/test_tmr_channel.sv
module test_tmr_channel;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_i = 1'b0;
    logic        gate_i = 1'b0;
    logic        mode_we_i = 1'b0;
    logic [2:0]  mode_code_i = 3'd0;
    logic        bcd_sel_i = 1'b0;
    logic        count_we_i = 1'b0;
    logic [15:0] count_i = 16'd0;
    logic        out_o;
    logic        loaded_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    tmr_channel i_tmr_channel (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tick_i),
        .gate_i      (gate_i),
        .mode_we_i   (mode_we_i),
        .mode_code_i (mode_code_i),
        .bcd_sel_i   (bcd_sel_i),
        .count_we_i  (count_we_i),
        .count_i     (count_i),
        .out_o       (out_o),
        .loaded_o    (loaded_o)
    );

    task automatic chk(input logic act, input logic exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic t, input logic g);
        tick_i = t;
        gate_i = g;
        @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic wr_mode(input logic [2:0] code, input logic b);
        mode_code_i = code;
        bcd_sel_i   = b;
        mode_we_i   = 1'b1;
        @(negedge clk);
        mode_we_i   = 1'b0;
    endtask

    task automatic wr_count(input logic [15:0] n);
        count_i    = n;
        count_we_i = 1'b1;
        @(negedge clk);
        count_we_i = 1'b0;
        chk(loaded_o, 1'b1, "R3 strobe after write");
    endtask

    task automatic t_reset();
        chk(out_o, 1'b1, "R1 out after reset");
        chk(loaded_o, 1'b0, "R1 loaded after reset");
    endtask

    task automatic t_term();
        wr_mode(3'b000, 1'b0);
        chk(out_o, 1'b0, "R4 low on mode write");
        repeat (5) cyc(1'b1, 1'b1);
        chk(out_o, 1'b0, "R13 no count before load");
        wr_count(16'd4);
        cyc(1'b0, 1'b1);
        chk(loaded_o, 1'b0, "R3 strobe one cycle");
        for (int k = 1; k <= 4; k++) begin
            cyc(1'b1, 1'b1);
            chk(out_o, (k == 4), "R4 terminal count");
        end
        repeat (6) cyc(1'b1, 1'b1);
        chk(out_o, 1'b1, "R4 stays high");
        wr_count(16'd3);
        chk(out_o, 1'b0, "R4 low on reload");
        repeat (4) cyc(1'b1, 1'b0);
        chk(out_o, 1'b0, "R5 gate low pauses");
        cyc(1'b1, 1'b1);
        cyc(1'b1, 1'b1);
        chk(out_o, 1'b0, "R5 two counted");
        cyc(1'b1, 1'b1);
        chk(out_o, 1'b1, "R5 third counted");
    endtask

    task automatic t_oneshot();
        gate_i = 1'b0;
        wr_mode(3'b001, 1'b0);
        chk(out_o, 1'b1, "R6 idle high");
        cyc(1'b0, 1'b1);
        cyc(1'b1, 1'b1);
        cyc(1'b1, 1'b0);
        chk(out_o, 1'b1, "R13 edge before load ignored");
        wr_count(16'd3);
        cyc(1'b0, 1'b1);
        cyc(1'b1, 1'b1);
        chk(out_o, 1'b0, "R6 low after trigger tick");
        for (int k = 1; k <= 3; k++) begin
            cyc(1'b1, 1'b1);
            chk(out_o, (k == 3), "R6 width N");
        end
        cyc(1'b0, 1'b0);
        cyc(1'b0, 1'b1);
        cyc(1'b1, 1'b1);
        cyc(1'b1, 1'b1);
        cyc(1'b0, 1'b0);
        cyc(1'b0, 1'b1);
        cyc(1'b1, 1'b1);
        cyc(1'b1, 1'b1);
        cyc(1'b1, 1'b1);
        chk(out_o, 1'b0, "R6 retrigger extends");
        cyc(1'b1, 1'b1);
        chk(out_o, 1'b1, "R6 retrigger end");
    endtask

    task automatic t_periodic(input logic [2:0] code, input logic b, input logic [15:0] nval,
                              input int n, input bit sq, input string req);
        int kk;
        logic hold;
        wr_mode(code, b);
        wr_count(nval);
        chk(out_o, 1'b1, req);
        kk = 0;
        for (int k = 1; k <= 2 * n + 2; k++) begin
            int r;
            int v;
            cyc(1'b1, 1'b1);
            kk = k;
            r = k % n;
            v = (r == 0) ? n : n - r;
            chk(out_o, sq ? (v > n / 2) : (v != 1), req);
        end
        hold = out_o;
        repeat (3) cyc(1'b1, 1'b0);
        chk(out_o, hold, "R5 divider paused");
        begin
            int r;
            int v;
            cyc(1'b1, 1'b1);
            kk++;
            r = kk % n;
            v = (r == 0) ? n : n - r;
            chk(out_o, sq ? (v > n / 2) : (v != 1), "R5 divider resumes");
        end
    endtask

    task automatic t_swstb();
        wr_mode(3'b100, 1'b0);
        wr_count(16'd3);
        cyc(1'b1, 1'b0);
        chk(out_o, 1'b1, "R5 strobe paused");
        for (int k = 1; k <= 4; k++) begin
            cyc(1'b1, 1'b1);
            chk(out_o, (k != 3), "R9 strobe timing");
        end
        repeat (8) cyc(1'b1, 1'b1);
        chk(out_o, 1'b1, "R9 fires once");
    endtask

    task automatic t_hwstb();
        gate_i = 1'b0;
        wr_mode(3'b101, 1'b0);
        wr_count(16'd4);
        repeat (6) cyc(1'b1, 1'b0);
        chk(out_o, 1'b1, "R10 waits for edge");
        cyc(1'b0, 1'b1);
        cyc(1'b1, 1'b1);
        chk(out_o, 1'b1, "R10 load tick");
        for (int k = 1; k <= 5; k++) begin
            cyc(1'b1, 1'b1);
            chk(out_o, (k != 4), "R10 strobe timing");
        end
        repeat (6) cyc(1'b1, 1'b1);
        chk(out_o, 1'b1, "R10 single strobe");
    endtask

    task automatic t_bcd();
        wr_mode(3'b000, 1'b1);
        wr_count(16'h0010);
        repeat (9) cyc(1'b1, 1'b1);
        chk(out_o, 1'b0, "R11 before tenth");
        cyc(1'b1, 1'b1);
        chk(out_o, 1'b1, "R11 tenth tick");
    endtask

    task automatic t_zero();
        wr_mode(3'b000, 1'b0);
        wr_count(16'd0);
        repeat (65535) cyc(1'b1, 1'b1);
        chk(out_o, 1'b0, "R12 binary before full");
        cyc(1'b1, 1'b1);
        chk(out_o, 1'b1, "R12 binary 65536");
        wr_mode(3'b000, 1'b1);
        wr_count(16'd0);
        repeat (9999) cyc(1'b1, 1'b1);
        chk(out_o, 1'b0, "R12 decimal before full");
        cyc(1'b1, 1'b1);
        chk(out_o, 1'b1, "R12 decimal 10000");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_term();
        t_oneshot();
        t_periodic(3'b010, 1'b0, 16'd4, 4, 1'b0, "R7 rate code 010");
        t_periodic(3'b110, 1'b0, 16'd3, 3, 1'b0, "R2 rate code 110");
        t_periodic(3'b011, 1'b0, 16'd5, 5, 1'b1, "R8 square odd");
        t_periodic(3'b111, 1'b0, 16'd6, 6, 1'b1, "R2 square code 111");
        t_periodic(3'b011, 1'b1, 16'h0015, 15, 1'b1, "R11 square decimal");
        t_swstb();
        t_hwstb();
        t_bcd();
        t_zero();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: got running expected done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule